// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for a small controller core. It counts ticks from one of three clock enables, chosen by a configuration strap: a low-speed crystal tick, a system-clock-divided-by-four tick, or an internal RC tick. The ticks pass through a binary prescaler whose ratio a 3-bit select sets, and then into an 8-bit counter. When the counter wraps, the block asks for a reset if the core is awake, or for a wake-up if the core is asleep.

Firmware can switch the watchdog off only by writing one code to a 4-bit key field, and only while the configuration strap does not force it on. Any other key value keeps it running. Two status flags tell firmware why it restarted. The time-out flag records a counter wrap. The power-down flag records that a halt instruction ran.

Top module: `wdt_guard`

## Requirements
- R1: `wdt_active_o` is low only when the key field holds 4'b1010 and `cfg_force_en_i` is low. Every other key value keeps the watchdog running.
- R2: After reset the key field holds 4'b1010, the prescale select holds 3'b111, and `wdt_active_o`, `wdt_rst_o`, `wake_o`, `to_flag_o` and `pd_flag_o` are all low.
- R3: While `cfg_force_en_i` is high, the watchdog runs whatever the key field holds.
- R4: `clk_sel_i` picks the tick source: 2'b00 is the crystal tick, 2'b01 is the system/4 tick, and 2'b10 or 2'b11 is the internal RC tick.
- R5: For prescale select n, the prescaler passes one tick in every 2^n source ticks, so 3'b000 gives 1:1 and 3'b111 gives 1:128. A time-out therefore takes 256·2^n source ticks after the counters were last zeroed. The request goes high in the cycle after the clock edge that samples the final tick.
- R6: While `sleep_i` is high and the system/4 source is selected, source ticks are ignored and the count does not advance.
- R7: A counter wrap while `sleep_i` is low raises `wdt_rst_o` for exactly one cycle. A wrap while `sleep_i` is high raises `wake_o` for exactly one cycle. Counting then continues from zero.
- R8: `to_flag_o` is set on every counter wrap. It is cleared by reset or by a clear strobe taken while the watchdog is active. Otherwise it holds its value.
- R9: `pd_flag_o` is set by a halt strobe and cleared by reset or by a clear strobe taken while the watchdog is active. A halt in the same cycle as a clear wins. A counter wrap does not change `pd_flag_o`.
- R10: While the watchdog is inactive, the prescaler and counter are held at zero, and a clear strobe leaves both flags unchanged.
- R11: A clear strobe taken while the watchdog is active zeroes the prescaler and the counter. It takes priority over a tick in the same cycle, so a full time-out period restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| cfg_force_en_i | input | 1 | Configuration strap that forces the watchdog on |
| clk_sel_i | input | 2 | Tick source select strap |
| xtal_tick_i | input | 1 | Crystal tick enable |
| sys4_tick_i | input | 1 | System-clock/4 tick enable |
| irc_tick_i | input | 1 | Internal RC tick enable |
| key_we_i | input | 1 | Write strobe for the key field |
| key_wdata_i | input | 4 | Key field write data |
| psel_we_i | input | 1 | Write strobe for the prescale select |
| psel_wdata_i | input | 3 | Prescale select write data |
| clr_wdt_i | input | 1 | Clear-watchdog strobe from the core |
| halt_i | input | 1 | Halt strobe from the core |
| sleep_i | input | 1 | Core is in sleep mode |
| wdt_active_o | output | 1 | Watchdog is running |
| wdt_rst_o | output | 1 | One-cycle reset request |
| wake_o | output | 1 | One-cycle wake request |
| to_flag_o | output | 1 | Time-out status flag |
| pd_flag_o | output | 1 | Power-down status flag |

## Verification
A wrong prescaler or counter value shows at the ports only as a reset or wake request in the wrong cycle. That can happen up to 32768 source ticks after the fault, so the bench runs at least one full period at every select value it uses and compares the request outputs on every cycle against a behavioural model. A wrong flag or enable state shows one cycle after the strobe that set it up. The bench therefore pulses clear and halt in both the active and the inactive state, including a halt and a clear together, and compares the flags on the next cycle.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned KEY_W  = 4;
  localparam int unsigned PSEL_W = 3;
  localparam int unsigned CNT_W  = 8;
  localparam logic [KEY_W-1:0] KEY_OFF = 4'b1010;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'b00,
    SRC_SYS4 = 2'b01,
    SRC_IRC  = 2'b10,
    SRC_IRC2 = 2'b11
  } src_e;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_guard_pkg::*;
(
  input  logic [1:0] clk_sel_i,
  input  logic       xtal_tick_i,
  input  logic       sys4_tick_i,
  input  logic       irc_tick_i,
  input  logic       sleep_i,
  output logic       tick_o
);
  src_e src;
  assign src = src_e'(clk_sel_i);

  always_comb begin
    unique case (src)
      SRC_XTAL: tick_o = xtal_tick_i;
      SRC_SYS4: tick_o = sys4_tick_i & ~sleep_i; // instruction clock stops in sleep
      default:  tick_o = irc_tick_i;
    endcase
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PSEL_W = 3,
  localparam int unsigned PRE_W = (1 << PSEL_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              tick_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  // ratio 2^psel: pass a tick when the low psel bits are all ones
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign mask[g] = psel_i > PSEL_W'(g);
  end

  assign tick_o = tick_i & ~hold_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic step_i,
  output logic wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = step_i & ~hold_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_force_en_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              xtal_tick_i,
  input  logic              sys4_tick_i,
  input  logic              irc_tick_i,
  input  logic              key_we_i,
  input  logic [KEY_W-1:0]  key_wdata_i,
  input  logic              psel_we_i,
  input  logic [PSEL_W-1:0] psel_wdata_i,
  input  logic              clr_wdt_i,
  input  logic              halt_i,
  input  logic              sleep_i,
  output logic              wdt_active_o,
  output logic              wdt_rst_o,
  output logic              wake_o,
  output logic              to_flag_o,
  output logic              pd_flag_o
);
  logic [KEY_W-1:0]  key_q;
  logic [PSEL_W-1:0] psel_q;
  logic src_tick, pre_tick, wrap, hold, clr_act;

  assign wdt_active_o = cfg_force_en_i | (key_q != KEY_OFF);
  assign clr_act      = clr_wdt_i & wdt_active_o;
  assign hold         = ~wdt_active_o | clr_wdt_i;

  wdt_tick_sel i_tick_sel (
    .clk_sel_i   (clk_sel_i),
    .xtal_tick_i (xtal_tick_i),
    .sys4_tick_i (sys4_tick_i),
    .irc_tick_i  (irc_tick_i),
    .sleep_i     (sleep_i),
    .tick_o      (src_tick)
  );

  wdt_prescaler #(.PSEL_W(PSEL_W)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .tick_i (src_tick),
    .psel_i (psel_q),
    .tick_o (pre_tick)
  );

  wdt_count #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .step_i (pre_tick),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q     <= KEY_OFF;
      psel_q    <= '1;
      wdt_rst_o <= 1'b0;
      wake_o    <= 1'b0;
      to_flag_o <= 1'b0;
      pd_flag_o <= 1'b0;
    end else begin
      if (key_we_i)  key_q  <= key_wdata_i;
      if (psel_we_i) psel_q <= psel_wdata_i;
      wdt_rst_o <= wrap & ~sleep_i;
      wake_o    <= wrap & sleep_i;
      if (clr_act)   to_flag_o <= 1'b0;
      else if (wrap) to_flag_o <= 1'b1;
      if (halt_i)       pd_flag_o <= 1'b1;
      else if (clr_act) pd_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_wdt_i,
  input logic halt_i,
  input logic wdt_active_o,
  input logic wdt_rst_o,
  input logic wake_o,
  input logic to_flag_o,
  input logic pd_flag_o
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R7
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R7
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_rst_o && wake_o)); // R7
  AST_REQ_SETS_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_o || wake_o) |-> to_flag_o); // R8
  AST_CLR_DROPS_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wdt_i && wdt_active_o) |=> !to_flag_o); // R8
  AST_HALT_SETS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> pd_flag_o); // R9
  AST_CLR_DROPS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wdt_i && wdt_active_o && !halt_i) |=> !pd_flag_o); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_active_o |=> !(wdt_rst_o || wake_o)); // R10
  AST_IDLE_CLR_KEEPS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wdt_i && !wdt_active_o && !halt_i) |=> pd_flag_o == $past(pd_flag_o)); // R10
endmodule

bind wdt_guard wdt_guard_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_wdt_i    (clr_wdt_i),
  .halt_i       (halt_i),
  .wdt_active_o (wdt_active_o),
  .wdt_rst_o    (wdt_rst_o),
  .wake_o       (wake_o),
  .to_flag_o    (to_flag_o),
  .pd_flag_o    (pd_flag_o)
);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic [1:0] src = 2'b10;
  logic xtal = 1'b0, sys4 = 1'b0, irc = 1'b0;
  logic key_we = 1'b0, psel_we = 1'b0, clr = 1'b0, halt = 1'b0, sleep = 1'b0;
  logic [3:0] key_d = 4'b0;
  logic [2:0] psel_d = 3'b0;
  logic act, rst_o, wake, to_f, pd_f;

  int total = 0, bad = 0, cyc = 0, rst_seen = 0, wake_seen = 0;
  bit cmp_on = 1'b0;

  // reference model state
  int m_key, m_psel, m_pre, m_cnt;
  bit m_rst, m_wake, m_to, m_pd;

  always #4 clk = ~clk; // 125 MHz

  wdt_guard i_wdt_guard (
    .clk_i(clk), .rst_ni(rst_n), .cfg_force_en_i(strap), .clk_sel_i(src),
    .xtal_tick_i(xtal), .sys4_tick_i(sys4), .irc_tick_i(irc),
    .key_we_i(key_we), .key_wdata_i(key_d), .psel_we_i(psel_we), .psel_wdata_i(psel_d),
    .clr_wdt_i(clr), .halt_i(halt), .sleep_i(sleep),
    .wdt_active_o(act), .wdt_rst_o(rst_o), .wake_o(wake), .to_flag_o(to_f), .pd_flag_o(pd_f)
  );

  task automatic chk(string req, int a, int e);
    total++;
    if (a != e) begin
      bad++;
      $display("FAIL %s: got %0d exp %0d at cycle %0d", req, a, e, cyc);
    end
  endtask

  function automatic bit m_active();
    return strap || (m_key != 10);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_key = 10; m_psel = 7; m_pre = 0; m_cnt = 0;
      m_rst = 0; m_wake = 0; m_to = 0; m_pd = 0;
    end else begin
      bit tk, wrap;
      int div;
      wrap = 0;
      case (src)
        2'b00: tk = xtal;
        2'b01: tk = sys4 && !sleep;
        default: tk = irc;
      endcase
      if (!m_active() || clr) begin
        m_pre = 0; m_cnt = 0;
        if (m_active()) begin m_to = 0; if (!halt) m_pd = 0; end
      end else if (tk) begin
        div = 1 << m_psel;
        if (m_pre % div == div - 1) begin
          if (m_cnt == 255) wrap = 1;
          m_cnt = (m_cnt + 1) % 256;
        end
        m_pre = (m_pre + 1) % 128;
      end
      m_rst = wrap && !sleep;
      m_wake = wrap && sleep;
      if (wrap) m_to = 1;
      if (halt) m_pd = 1;
      if (key_we) m_key = key_d;
      if (psel_we) m_psel = psel_d;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk("R1 active", act, m_active());
      chk("R7 reset req", rst_o, m_rst);
      chk("R7 wake req", wake, m_wake);
      chk("R8 to flag", to_f, m_to);
      chk("R9 pd flag", pd_f, m_pd);
      if (rst_o) rst_seen++;
      if (wake) wake_seen++;
    end
    xtal <= (cyc % 2) == 0;
    sys4 <= (cyc % 4) == 0;
    irc  <= 1'b1;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: got %0d exp %0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  task automatic pulse_halt();
    halt = 1'b1; step(1); halt = 1'b0;
  endtask

  task automatic wr_key(logic [3:0] v);
    key_d = v; key_we = 1'b1; step(1); key_we = 1'b0;
  endtask

  task automatic wr_psel(logic [2:0] v);
    psel_d = v; psel_we = 1'b1; step(1); psel_we = 1'b0;
  endtask

  initial begin
    int n, r0, w0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R2 reset state
    chk("R2 active", act, 0);
    chk("R2 rst", rst_o, 0);
    chk("R2 wake", wake, 0);
    chk("R2 to", to_f, 0);
    chk("R2 pd", pd_f, 0);
    cmp_on = 1'b1;

    // R10: idle, no request; clear keeps pd
    step(600);
    chk("R10 no req idle", rst_seen, 0);
    pulse_halt();
    pulse_clr();
    chk("R10 pd kept", pd_f, 1);

    // R5: psel 0, IRC, exact time-out count
    psel_d = 3'd0; psel_we = 1'b1; key_d = 4'b0101; key_we = 1'b1;
    n = 0;
    step(1); psel_we = 1'b0; key_we = 1'b0; n = 1;
    while (!rst_o && n < 2000) begin step(1); n++; end
    chk("R5 timeout cycles", n, 257);
    step(1);
    chk("R8 to set", to_f, 1);
    chk("R9 pd kept on wrap", pd_f, 1);

    // R1: other key value keeps it running
    wr_key(4'b1111);
    chk("R1 other key active", act, 1);
    pulse_clr();
    chk("R8 to cleared", to_f, 0);
    chk("R9 pd cleared", pd_f, 0);

    // R11: periodic clears prevent a time-out
    r0 = rst_seen;
    for (int i = 0; i < 5; i++) begin step(200); pulse_clr(); end
    chk("R11 no req with clears", rst_seen - r0, 0);

    // R4/R5: crystal source, psel 2
    src = 2'b00; wr_psel(3'd2); pulse_clr();
    r0 = rst_seen;
    step(2100);
    chk("R4 xtal timeout", rst_seen - r0, 1);

    // R6: sys/4 stops in sleep
    pulse_halt();
    src = 2'b01; sleep = 1'b1; pulse_clr(); pulse_halt();
    w0 = wake_seen;
    step(5000);
    chk("R6 sys4 halted", wake_seen - w0, 0);

    // R7: IRC wakes while asleep, pd stays set
    src = 2'b11;
    step(1100);
    chk("R7 wake", wake_seen - w0, 1);
    chk("R9 pd after wake", pd_f, 1);
    sleep = 1'b0;

    // R9: halt wins over clear
    clr = 1'b1; halt = 1'b1; step(1); clr = 1'b0; halt = 1'b0;
    chk("R9 halt wins", pd_f, 1);

    // R3: strap forces run with disable key
    strap = 1'b1; src = 2'b10;
    wr_key(4'b1010);
    chk("R3 forced active", act, 1);
    pulse_clr();
    r0 = rst_seen;
    step(1100);
    chk("R3 forced timeout", rst_seen - r0, 1);
    strap = 1'b0;
    step(1);
    chk("R1 key off", act, 0);

    // R5: longest select
    wr_key(4'b0101); wr_psel(3'd7); pulse_clr();
    r0 = rst_seen;
    step(32800);
    chk("R5 psel7 timeout", rst_seen - r0, 1);

    step(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule